// File: doc/BRIEF.md
# Speech Downlink Gain Stage

This block scales the speech samples on the receive path before they reach the output converter. It takes one signed sample per valid strobe. Each sample gets a coarse volume attenuation in 6 dB steps and a fine calibration gain in 1 dB steps around unity. A mute forces silence, and a bypass passes the sample through without scaling.

The coarse volume is an arithmetic right shift, because 6 dB is one factor of two. The fine gain multiplies by a Q2.14 constant that approximates the decibel value. Results beyond the 16-bit range saturate. The settings are taken in the same cycle as the sample they apply to. A later change to the settings therefore never mixes into a sample that is already being computed.

Top module: `speech_gain`

## Requirements
- R1: Every input strobe (`in_valid` high at a rising edge) produces exactly one `out_valid` pulse two clock cycles later. Output strobes keep the order of the input strobes, and back-to-back input is accepted on every cycle.
- R2: With fine code 6, volume code 0, mute low and bypass low, the output equals the input exactly.
- R3: Volume code v (0 to 4) attenuates by v times 6 dB, which is a division by 2^v rounded toward minus infinity. Codes 5, 6 and 7 behave like code 4 (-24 dB).
- R4: Fine code f (0 to 12) applies a gain of (f-6) dB through the coefficient K = round(16384 * 10^((f-6)/20)). Together with R3, the result is floor(x*K / 2^(14+v)). Codes 13, 14 and 15 behave like code 6 (unity).
- R5: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R6: When mute is high, the output is exactly zero, whatever the bypass, volume and fine settings are.
- R7: When bypass is high and mute is low, the output equals the input, and the volume and fine codes have no effect.
- R8: Volume, fine, mute and bypass are sampled in the same cycle as `in_valid`. Changing them in later cycles does not alter the output for that sample.
- R9: After reset, `out_valid` is 0 and `out_sample` is 0. Between output strobes, `out_sample` holds its last value.
- R10: When mute is low, the sign bit of the output equals the sign bit of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| cfg_volume | input | 3 | Coarse volume code, 0 = 0 dB, 4 = -24 dB |
| cfg_fine | input | 4 | Fine gain code, 6 = 0 dB, 0 = -6 dB, 12 = +6 dB |
| cfg_mute | input | 1 | Force output to zero |
| cfg_bypass | input | 1 | Pass the sample through unscaled |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed scaled sample |

## Verification
The assertions check on every cycle the properties that need no arithmetic model: the two-cycle strobe latency, zero output under mute, exact pass-through under bypass and at unity settings, the held output between strobes, and sign preservation. The numeric scaling can only be shown by the bench's sweep, which compares against an independently computed decibel model. That covers the rounding of the fine-gain constants, floor division by the volume shift, saturation at both rails, and the clamping of out-of-range codes. The bench also alters the settings right after each strobe to show that a pending sample keeps the settings it was captured with.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
   localparam int VOL_W     = 3;
   localparam int FINE_W    = 4;
   localparam int COEF_W    = 16;
   localparam int COEF_FRAC = 14;
   localparam int FINE_N    = 13;
   localparam int FINE_MID  = 6;

   typedef struct packed {
      logic [VOL_W-1:0]  vol;
      logic [FINE_W-1:0] fine;
      logic              mute;
      logic              byp;
   } gain_cfg_t;

   // Q2.14 approximations of 10^(g/20), g = code - 6
   function automatic logic signed [COEF_W-1:0] fine_coef(input logic [FINE_W-1:0] code);
      logic signed [COEF_W-1:0] k;
      case (code)
         4'd0:    k = 16'sd8211;
         4'd1:    k = 16'sd9213;
         4'd2:    k = 16'sd10338;
         4'd3:    k = 16'sd11599;
         4'd4:    k = 16'sd13014;
         4'd5:    k = 16'sd14602;
         4'd7:    k = 16'sd18383;
         4'd8:    k = 16'sd20626;
         4'd9:    k = 16'sd23143;
         4'd10:   k = 16'sd25967;
         4'd11:   k = 16'sd29135;
         4'd12:   k = 16'sd32690;
         default: k = 16'sd16384;
      endcase
      return k;
   endfunction
endpackage

// File: rtl/sgs_capture.sv
module sgs_capture
   import sgs_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int VOL_MAX = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_sample,
   input  logic [VOL_W-1:0]  in_vol,
   input  logic [FINE_W-1:0] in_fine,
   input  logic              in_mute,
   input  logic              in_byp,
   output logic              cap_valid,
   output logic [DATA_W-1:0] cap_sample,
   output gain_cfg_t         cap_cfg
);
   localparam logic [VOL_W-1:0]  VOL_LIM  = VOL_W'(VOL_MAX);
   localparam logic [FINE_W-1:0] FINE_TOP = FINE_W'(FINE_N - 1);
   localparam logic [FINE_W-1:0] FINE_ONE = FINE_W'(FINE_MID);

   gain_cfg_t cfg_d;

   always_comb begin
      cfg_d.vol  = (in_vol > VOL_LIM) ? VOL_LIM : in_vol;
      cfg_d.fine = (in_fine > FINE_TOP) ? FINE_ONE : in_fine;
      cfg_d.mute = in_mute;
      cfg_d.byp  = in_byp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_valid  <= 1'b0;
         cap_sample <= '0;
         cap_cfg    <= '0;
      end else begin
         cap_valid <= in_valid;
         if (in_valid) begin
            cap_sample <= in_sample;
            cap_cfg    <= cfg_d;
         end
      end
   end
endmodule

// File: rtl/sgs_scale.sv
module sgs_scale
   import sgs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PROD_W = DATA_W + COEF_W
) (
   input  logic [DATA_W-1:0] sample,
   input  logic [VOL_W-1:0]  vol,
   input  logic [FINE_W-1:0] fine,
   output logic [PROD_W-1:0] scaled
);
   localparam int SH_W = 6;

   logic signed [DATA_W-1:0] s_in;
   logic signed [COEF_W-1:0] coef;
   logic signed [PROD_W-1:0] s_ext, c_ext, prod;
   logic [SH_W-1:0]          shamt;

   always_comb begin
      s_in   = $signed(sample);
      coef   = fine_coef(fine);
      s_ext  = PROD_W'(s_in);
      c_ext  = PROD_W'(coef);
      prod   = s_ext * c_ext;
      shamt  = SH_W'(COEF_FRAC) + SH_W'(vol);
      scaled = prod >>> shamt;
   end
endmodule

// File: rtl/sgs_limit.sv
module sgs_limit #(
   parameter int IN_W     = 32,
   parameter int OUT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam logic [OUT_W-1:0] POS_RAIL = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_RAIL = {1'b1, {(OUT_W-1){1'b0}}};

   if (IN_W <= OUT_W) begin : g_bad_width
      $error("sgs_limit: input must be wider than output");
   end

   if (SATURATE) begin : g_sat
      logic fits;
      always_comb begin
         fits = (&din[IN_W-1:OUT_W-1]) | ~(|din[IN_W-1:OUT_W-1]);
         if (fits)
            dout = din[OUT_W-1:0];
         else
            dout = din[IN_W-1] ? NEG_RAIL : POS_RAIL;
      end
   end else begin : g_wrap
      logic unused_hi;
      assign unused_hi = ^din[IN_W-1:OUT_W];
      assign dout = din[OUT_W-1:0];
   end
endmodule

// File: rtl/speech_gain.sv
module speech_gain
   import sgs_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int VOL_MAX  = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_sample,
   input  logic [2:0]        cfg_volume,
   input  logic [3:0]        cfg_fine,
   input  logic              cfg_mute,
   input  logic              cfg_bypass,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_sample
);
   localparam int PROD_W = DATA_W + COEF_W;

   if (DATA_W < 8 || DATA_W > 24) begin : g_bad_data_w
      $error("speech_gain: DATA_W out of supported range");
   end
   if (VOL_MAX < 0 || VOL_MAX > (1 << VOL_W) - 1) begin : g_bad_vol
      $error("speech_gain: VOL_MAX does not fit the volume code");
   end

   logic              cap_valid;
   logic [DATA_W-1:0] cap_sample;
   gain_cfg_t         cap_cfg;
   logic [PROD_W-1:0] scaled;
   logic [DATA_W-1:0] limited;
   logic [DATA_W-1:0] result;

   sgs_capture #(.DATA_W(DATA_W), .VOL_MAX(VOL_MAX)) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .in_vol     (cfg_volume),
      .in_fine    (cfg_fine),
      .in_mute    (cfg_mute),
      .in_byp     (cfg_bypass),
      .cap_valid  (cap_valid),
      .cap_sample (cap_sample),
      .cap_cfg    (cap_cfg)
   );

   sgs_scale #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_scale (
      .sample (cap_sample),
      .vol    (cap_cfg.vol),
      .fine   (cap_cfg.fine),
      .scaled (scaled)
   );

   sgs_limit #(.IN_W(PROD_W), .OUT_W(DATA_W), .SATURATE(SATURATE)) u_limit (
      .din  (scaled),
      .dout (limited)
   );

   always_comb begin
      if (cap_cfg.mute)
         result = '0;
      else if (cap_cfg.byp)
         result = cap_sample;
      else
         result = limited;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= cap_valid;
         if (cap_valid)
            out_sample <= result;
      end
   end
endmodule

// File: rtl/speech_gain_chk.sv
module speech_gain_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_sample,
   input logic [2:0]        cfg_volume,
   input logic [3:0]        cfg_fine,
   input logic              cfg_mute,
   input logic              cfg_bypass,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_sample
);
   logic [1:0] age;
   logic       warm;

   always_ff @(posedge clk) begin
      if (!rst_n)
         age <= 2'd0;
      else if (age != 2'd3)
         age <= age + 2'd1;
   end
   assign warm = (age >= 2'd2);

   AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_valid == $past(in_valid, 2))); // R1

   AST_UNITY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(in_valid && !cfg_mute && !cfg_bypass &&
       cfg_volume == 3'd0 && cfg_fine == 4'd6, 2))
      |-> (out_sample == $past(in_sample, 2))); // R2

   AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(in_valid && cfg_mute, 2))
      |-> (out_sample == '0)); // R6

   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(in_valid && cfg_bypass && !cfg_mute, 2))
      |-> (out_sample == $past(in_sample, 2))); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_sample)); // R9

   AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(in_valid && !cfg_mute, 2))
      |-> (out_sample[DATA_W-1] == $past(in_sample[DATA_W-1], 2))); // R10
endmodule

bind speech_gain speech_gain_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/speech_gain_bench.sv
module speech_gain_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_sample = '0;
   logic [2:0]  cfg_volume = '0;
   logic [3:0]  cfg_fine = 4'd6;
   logic        cfg_mute = 1'b0;
   logic        cfg_bypass = 1'b0;
   logic        out_valid;
   logic [15:0] out_sample;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   speech_gain u_speech_gain (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .cfg_volume(cfg_volume), .cfg_fine(cfg_fine), .cfg_mute(cfg_mute),
      .cfg_bypass(cfg_bypass), .out_valid(out_valid), .out_sample(out_sample)
   );

   function automatic int pick(int i);
      case (i)
         0: return 0;        1: return 1;       2: return -1;
         3: return 32767;    4: return -32768;  5: return 1000;
         6: return -1000;    7: return 12345;   8: return -23456;
         9: return 20000;    default: return -3;
      endcase
   endfunction

   function automatic int model(int x, int v, int f, bit m, bit b);
      int ve, fe, k;
      longint p;
      if (m) return 0;
      if (b) return x;
      ve = (v > 4) ? 4 : v;
      fe = (f > 12) ? 6 : f;
      k  = $rtoi(16384.0 * (10.0 ** ((fe - 6) / 20.0)) + 0.5);
      p  = longint'(x) * longint'(k);
      p  = p >>> (14 + ve);
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      return int'(p);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one sample; settings scrambled right after capture (R8)
   task automatic send(int x, int v, int f, bit m, bit b, string req);
      int exp, act;
      @(negedge clk);
      in_valid = 1'b1; in_sample = 16'(x);
      cfg_volume = 3'(v); cfg_fine = 4'(f); cfg_mute = m; cfg_bypass = b;
      @(negedge clk);
      in_valid = 1'b0; in_sample = ~in_sample;
      cfg_volume = ~cfg_volume; cfg_fine = ~cfg_fine; cfg_mute = ~m; cfg_bypass = ~b;
      @(negedge clk);
      exp = model(x, v, f, m, b);
      act = int'($signed(out_sample));
      check(out_valid == 1'b1, "R1", int'(out_valid), 1);
      check(act == exp, req, act, exp);
      if (!m) check(out_sample[15] == x[15], "R10", int'(out_sample[15]), int'(x[15]));
      @(negedge clk);
      check(out_valid == 1'b0 && int'($signed(out_sample)) == exp, "R9",
            int'($signed(out_sample)), exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R9", int'(out_valid), 0);
      check(out_sample == 16'd0, "R9", int'(out_sample), 0);
      rst_n = 1'b1;

      // R2 unity
      for (int i = 0; i < 11; i++) send(pick(i), 0, 6, 1'b0, 1'b0, "R2");
      // R3 R4 R5 R8 full sweep of codes, including out-of-range codes
      for (int v = 0; v < 8; v++)
         for (int f = 0; f < 16; f++)
            for (int i = 0; i < 11; i++)
               send(pick(i), v, f, 1'b0, 1'b0,
                    (pick(i) == 32767 || pick(i) == -32768) ? "R5" :
                    (f == 6) ? "R3" : "R4");
      // R5 explicit rails at +6 dB
      send(32767, 0, 12, 1'b0, 1'b0, "R5");
      send(-32768, 0, 12, 1'b0, 1'b0, "R5");
      // R6 mute over bypass and all volumes
      for (int v = 0; v < 8; v++)
         for (int i = 0; i < 11; i++) send(pick(i), v, 12, 1'b1, v[0], "R6");
      // R7 bypass ignores volume and fine
      for (int v = 0; v < 8; v++)
         for (int f = 0; f < 16; f += 5)
            for (int i = 0; i < 11; i++) send(pick(i), v, f, 1'b0, 1'b1, "R7");

      // R1 back-to-back stream
      @(negedge clk);
      cfg_volume = 3'd1; cfg_fine = 4'd6; cfg_mute = 1'b0; cfg_bypass = 1'b0;
      for (int j = 0; j < 6; j++) begin
         in_valid = 1'b1; in_sample = 16'(pick(j + 3));
         if (j >= 2) begin
            check(out_valid == 1'b1, "R1", int'(out_valid), 1);
            check(int'($signed(out_sample)) == model(pick(j + 1), 1, 6, 1'b0, 1'b0), "R1",
                  int'($signed(out_sample)), model(pick(j + 1), 1, 6, 1'b0, 1'b0));
         end
         @(negedge clk);
      end
      in_valid = 1'b0;
      for (int j = 6; j < 8; j++) begin
         check(out_valid == 1'b1, "R1", int'(out_valid), 1);
         check(int'($signed(out_sample)) == model(pick(j + 1), 1, 6, 1'b0, 1'b0), "R1",
               int'($signed(out_sample)), model(pick(j + 1), 1, 6, 1'b0, 1'b0));
         @(negedge clk);
      end
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule